// File: doc/BRIEF.md
# Octal Bidirectional Latched Transceiver

This block carries an 8-bit word between two ports, A and B. Each direction has its own bank of storage cells. The A-to-B bank takes its word from port A and presents it on port B. The B-to-A bank takes its word from port B and presents it on port A. Each direction is steered by three active-low controls: a chip select, a capture (latch) enable and a drive enable. The two directions share no state, so one direction can capture or hold while the other does something else.

Each port has a separate input word, output word and drive flag. Together these stand in for a tri-state pad. The integrator places the pad cell and connects the drive flag to its enable. The storage cells are modelled as clocked registers. A bank loads its input word on every clock edge at which both its chip select and its capture enable are low. At every other edge the bank keeps its word. Raising the capture enable therefore freezes the last word taken.

The reset input is asynchronous and active low. Its release is synchronised to the clock. Reset clears both banks to zero.

Top module: `octal_latch_xcvr`

## Requirements
- R1: While reset is applied, and after it is released until the first capture, both banks hold zero. `b_out` and `a_out` then read 0x00.
- R2: At a clock edge where `ab_sel_n` and `ab_cap_n` are both 0, the A-to-B bank loads `a_in`. `b_out` shows that word from just after that edge.
- R3: At a clock edge where `ab_sel_n` is 0 and `ab_cap_n` is 1, the A-to-B bank keeps its word. `b_out` does not follow `a_in`.
- R4: At a clock edge where `ab_sel_n` is 1, the A-to-B bank keeps its word whatever `ab_cap_n` and `a_in` are.
- R5: `b_drive` is 1 exactly when `ab_sel_n` and `ab_drv_n` are both 0. It is 0 whenever either of them is 1. The flag follows the controls in the same cycle.
- R6: At a clock edge where `ba_sel_n` and `ba_cap_n` are both 0, the B-to-A bank loads `b_in`. `a_out` shows that word from just after that edge.
- R7: At a clock edge where `ba_sel_n` or `ba_cap_n` is 1, the B-to-A bank keeps its word.
- R8: `a_drive` is 1 exactly when `ba_sel_n` and `ba_drv_n` are both 0. It is 0 whenever either of them is 1. The flag follows the controls in the same cycle.
- R9: Captures and control changes in one direction leave the other direction's stored word unchanged.
- R10: Both directions may drive in the same cycle. `a_drive` and `b_drive` are then both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised |
| a_in | input | 8 | Word arriving at port A |
| a_out | output | 8 | B-to-A bank contents presented at port A |
| a_drive | output | 1 | Port A pad drive enable |
| b_in | input | 8 | Word arriving at port B |
| b_out | output | 8 | A-to-B bank contents presented at port B |
| b_drive | output | 1 | Port B pad drive enable |
| ab_sel_n | input | 1 | A-to-B chip select, active low |
| ab_cap_n | input | 1 | A-to-B capture enable, active low |
| ab_drv_n | input | 1 | A-to-B drive enable, active low |
| ba_sel_n | input | 1 | B-to-A chip select, active low |
| ba_cap_n | input | 1 | B-to-A capture enable, active low |
| ba_drv_n | input | 1 | B-to-A drive enable, active low |

## Verification
The drive flags are combinational, so they are due in the same cycle as the control change. The bench applies inputs at the falling edge and checks the flags 2 ns later. A captured word is due one register stage later: it appears just after the rising edge that sees the load condition. The bench updates its model at that edge and compares both output words 2 ns after it. Release of reset takes two synchroniser edges, so the bench waits three cycles before it checks the cleared state. Random control mixes are interleaved with directed cases for holds, for isolation between the directions and for both directions driving at once.

// File: rtl/octal_latch_xcvr_pkg.sv
package octal_latch_xcvr_pkg;

  // Per-direction control group, every field active low
  typedef struct packed {
    logic sel_n;
    logic cap_n;
    logic drv_n;
  } dir_ctrl_t;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/xcvr_store_bank.sv
module xcvr_store_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // One storage cell per bit: separate next-state and register processes
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic cell_q;
    logic cell_d;

    always_comb begin
      cell_d = cell_q;
      if (load_en) cell_d = d[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= 1'b0;
      else        cell_q <= cell_d;
    end

    assign q[i] = cell_q;
  end

endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
  import octal_latch_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dir_ctrl_t        ctrl,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst,
  output logic             drive
);

  logic load_en;

  always_comb begin
    load_en = ~ctrl.sel_n & ~ctrl.cap_n;
    drive   = ~ctrl.sel_n & ~ctrl.drv_n;
  end

  xcvr_store_bank #(.WIDTH(WIDTH)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .d       (src),
    .q       (dst)
  );

endmodule

// File: rtl/octal_latch_xcvr.sv
module octal_latch_xcvr
  import octal_latch_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  input  logic             ab_sel_n,
  input  logic             ab_cap_n,
  input  logic             ab_drv_n,
  input  logic             ba_sel_n,
  input  logic             ba_cap_n,
  input  logic             ba_drv_n
);

  logic      rst_sync_n;
  dir_ctrl_t ab_ctrl;
  dir_ctrl_t ba_ctrl;

  assign ab_ctrl = '{sel_n: ab_sel_n, cap_n: ab_cap_n, drv_n: ab_drv_n};
  assign ba_ctrl = '{sel_n: ba_sel_n, cap_n: ba_cap_n, drv_n: ba_drv_n};

  xcvr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xcvr_dir_path #(.WIDTH(WIDTH)) u_ab (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ctrl  (ab_ctrl),
    .src   (a_in),
    .dst   (b_out),
    .drive (b_drive)
  );

  xcvr_dir_path #(.WIDTH(WIDTH)) u_ba (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ctrl  (ba_ctrl),
    .src   (b_in),
    .dst   (a_out),
    .drive (a_drive)
  );

endmodule

// File: rtl/octal_latch_xcvr_chk.sv
module octal_latch_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_drive,
  input logic             ab_sel_n,
  input logic             ab_cap_n,
  input logic             ab_drv_n,
  input logic             ba_sel_n,
  input logic             ba_cap_n,
  input logic             ba_drv_n
);

  // Becomes 1 once a full cycle out of reset lies behind, so $past is valid
  logic armed;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  // R5
  ab_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ab_sel_n || ab_drv_n) |-> !b_drive);
  // R5
  ab_drive_on_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ab_sel_n && !ab_drv_n) |-> b_drive);
  // R8
  ba_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ba_sel_n || ba_drv_n) |-> !a_drive);
  // R8
  ba_drive_on_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ba_sel_n && !ba_drv_n) |-> a_drive);
  // R2
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && !$past(ab_sel_n) && !$past(ab_cap_n)) |-> (b_out == $past(a_in)));
  // R3
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && ($past(ab_sel_n) || $past(ab_cap_n))) |-> $stable(b_out));
  // R6
  ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && !$past(ba_sel_n) && !$past(ba_cap_n)) |-> (a_out == $past(b_in)));
  // R7
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && ($past(ba_sel_n) || $past(ba_cap_n))) |-> $stable(a_out));

endmodule

bind octal_latch_xcvr octal_latch_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .a_in       (a_in),
  .a_out      (a_out),
  .a_drive    (a_drive),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_drive    (b_drive),
  .ab_sel_n   (ab_sel_n),
  .ab_cap_n   (ab_cap_n),
  .ab_drv_n   (ab_drv_n),
  .ba_sel_n   (ba_sel_n),
  .ba_cap_n   (ba_cap_n),
  .ba_drv_n   (ba_drv_n)
);

// File: tb/octal_latch_xcvr_tb.sv
`timescale 1ns/1ps
module octal_latch_xcvr_tb;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_drive, b_drive;
  logic         ab_sel_n, ab_cap_n, ab_drv_n;
  logic         ba_sel_n, ba_cap_n, ba_drv_n;

  int n_checks   = 0;
  int n_fail     = 0;
  int n_conflict = 0;
  logic [W-1:0] ab_m, ba_m;

  octal_latch_xcvr #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .ab_sel_n(ab_sel_n), .ab_cap_n(ab_cap_n), .ab_drv_n(ab_drv_n),
    .ba_sel_n(ba_sel_n), .ba_cap_n(ba_cap_n), .ba_drv_n(ba_drv_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic exp_drive(input logic sel_n, input logic drv_n);
    return !sel_n && !drv_n;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // c = {ab_sel_n, ab_cap_n, ab_drv_n, ba_sel_n, ba_cap_n, ba_drv_n}
  task automatic run_cycle(input logic [W-1:0] av, input logic [W-1:0] bv, input logic [5:0] c);
    string ab_tag, ba_tag;
    logic  eb, ea;
    {ab_sel_n, ab_cap_n, ab_drv_n, ba_sel_n, ba_cap_n, ba_drv_n} = c;
    a_in = av;
    b_in = bv;
    #2;
    eb = exp_drive(c[5], c[3]);
    ea = exp_drive(c[2], c[0]);
    check(b_drive === eb, "R5", 32'(b_drive), 32'(eb));
    check(a_drive === ea, "R8", 32'(a_drive), 32'(ea));
    if (eb && ea) begin
      n_conflict++;
      check(a_drive && b_drive, "R10", {30'd0, a_drive, b_drive}, 32'd3);
    end
    @(posedge clk);
    if (!c[5] && !c[4]) begin ab_m = av; ab_tag = "R2"; end
    else ab_tag = c[5] ? "R4" : "R3";
    if (!c[2] && !c[1]) begin ba_m = bv; ba_tag = "R6"; end
    else ba_tag = "R7";
    #2;
    check(b_out === ab_m, ab_tag, 32'(b_out), 32'(ab_m));
    check(a_out === ba_m, ba_tag, 32'(a_out), 32'(ba_m));
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [W-1:0] keep;
    logic [5:0]   c;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    a_in = '0; b_in = '0;
    {ab_sel_n, ab_cap_n, ab_drv_n, ba_sel_n, ba_cap_n, ba_drv_n} = 6'b111111;
    ab_m = '0; ba_m = '0;
    repeat (3) @(negedge clk);
    // R1: cleared during reset
    check(b_out === '0, "R1", 32'(b_out), 0);
    check(a_out === '0, "R1", 32'(a_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: still cleared after release, before any capture
    check(b_out === '0, "R1", 32'(b_out), 0);
    check(a_out === '0, "R1", 32'(a_out), 0);

    // Directed: A-to-B capture, B-to-A deselected (R2, R9)
    run_cycle(8'hA5, 8'h3C, 6'b001111);
    check(a_out === '0, "R9", 32'(a_out), 0);
    // R3: capture enable high, A changes, B output holds
    run_cycle(8'h5A, 8'h00, 6'b011111);
    check(b_out === 8'hA5, "R3", 32'(b_out), 32'hA5);
    // R4: select high with capture low, held
    run_cycle(8'hFF, 8'h00, 6'b101111);
    check(b_out === 8'hA5, "R4", 32'(b_out), 32'hA5);
    // R6 and R9: B-to-A capture while A-to-B is idle
    keep = b_out;
    run_cycle(8'h00, 8'hC3, 6'b111001);
    check(b_out === keep, "R9", 32'(b_out), 32'(keep));
    check(a_out === 8'hC3, "R6", 32'(a_out), 32'hC3);
    // R10: both directions capture and drive together, extreme words
    run_cycle(8'hFF, 8'h00, 6'b000000);
    run_cycle(8'h00, 8'hFF, 6'b000000);
    // R5/R8: drive enables high with select low
    run_cycle(8'h11, 8'h22, 6'b011011);

    // Constrained random: select mostly low
    for (int i = 0; i < 400; i++) begin
      c[5] = ($urandom % 4) == 0;
      c[4] = $urandom % 2;
      c[3] = $urandom % 2;
      c[2] = ($urandom % 4) == 0;
      c[1] = $urandom % 2;
      c[0] = $urandom % 2;
      run_cycle(W'($urandom), W'($urandom), c);
    end

    $display("Info: both directions driving in %0d cycles", n_conflict);
    summary();
  end

endmodule